// File: doc/BRIEF.md
# Chainable Interval Timer

A single-channel general-purpose interval timer driven through a small register port. It counts down from a load value or up to it, with an 8-bit prescaler in front of the counter. It runs in one-shot, periodic or PWM mode. Each timeout drives a one-cycle pulse on `chain_out`, so the next timer in a daisy chain can use it as a start trigger. A timer set to wait for a trigger holds its count until a pulse arrives on `chain_in`.

Software chooses whether a new load or prescale value takes effect at once or is held until the next timeout. In periodic mode the readable count and prescale registers can be switched to show a snapshot taken at the last timeout. A match register compares against the count and raises a match event. The match event is passed on to external DMA and ADC trigger pins only while the match interrupt enable is set.

The register port is plain: one write per cycle, and a read address that drives `rd_data` combinationally. The block moves no data stream, so it has no valid/ready handshake and no back-pressure.

Register addresses: 0 config, 1 load, 2 prescale, 3 match, 4 count readback, 5 prescale readback, 6 status (write 1 to clear), 7 masked status. Config bits: [0] run enable, [2:1] mode (00 one-shot, 01 periodic, 10 PWM), [3] count up, [4] defer reload, [5] snapshot, [6] wait for trigger, [7] match interrupt enable, [8] timeout interrupt enable, [9] DMA match trigger enable, [10] ADC match trigger enable. Status bits: [0] timeout, [1] match.

Top module: `chain_timer`

## Requirements
- R1: After reset, config, status and count read as 0, and `irq`, `chain_out`, `pwm_out`, `dma_match_trig` and `adc_match_trig` are low.
- R2: In periodic mode with load L and prescale P, timeouts come every (L+1)*(P+1) cycles. Counting down runs L to 0 and counting up (config bit 3) runs 0 to L. Each timeout gives one `chain_out` pulse.
- R3: When counting down with config bit 4 clear, a write to the load register (address 1) sets the count to the new value on the next clock edge. A write to the prescale register (address 2) likewise sets the prescaler at once.
- R4: When counting down with config bit 4 set, a load or prescale write leaves the running count alone. The new values take effect from the next timeout.
- R5: When counting up, config bit 4 has no effect: a new load value becomes the upper limit at once.
- R6: A load value written while the timer is disabled (config bit 0 clear) is loaded into the count on the cycle after the enable is set.
- R7: In one-shot mode (mode 00) the timer times out once, and config bit 0 then reads 0.
- R8: In periodic mode with config bit 5 set, address 4 returns the count and address 5 returns the prescaler value, both as latched at the last timeout.
- R9: With config bit 6 set, an enabled timer holds its count and makes no timeout until a pulse on `chain_in`. It then counts as normal. With bit 6 clear it starts as soon as it is enabled.
- R10: When the count reaches the match value (address 3) on a prescaler tick in one-shot or periodic mode, status bit 1 sets. PWM mode never sets it.
- R11: A match event pulses `dma_match_trig` (enabled by config bit 9) and `adc_match_trig` (enabled by config bit 10) only while config bit 7 is set.
- R12: Status bits are sticky and are cleared by writing 1 to them at address 6; writing 0 leaves them unchanged. `irq` is high when status bit 0 is set with config bit 8 set, or when status bit 1 is set with config bit 7 set.
- R13: In PWM mode the timer counts down periodically, and `pwm_out` is high while the count is above the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| chain_in | input | 1 | Start trigger from the previous timer |
| chain_out | output | 1 | One-cycle timeout pulse to the next timer |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Masked interrupt |
| dma_match_trig | output | 1 | Match trigger toward DMA |
| adc_match_trig | output | 1 | Match trigger toward ADC |

## Verification
The assertions check on every cycle that:
- each timeout sets the sticky timeout status;
- every DMA or ADC trigger pulse leaves the match status set;
- a one-shot timeout clears the run enable;
- a timer waiting for its trigger keeps its count unchanged;
- the prescaler never runs above its active reload value while counting.

Only the bench's scenarios can show the rest:
- the exact periods for each direction and prescale;
- that a reload takes effect at once or is deferred;
- the values held by the snapshot;
- the delay from a trigger to the first timeout;
- the PWM duty count.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_PWM      = 2'd2,
    MODE_RSVD     = 2'd3
  } tmode_e;

  // Packed from MSB: bit 10 down to bit 0.
  typedef struct packed {
    logic   adc_en;
    logic   dma_en;
    logic   to_ie;
    logic   match_ie;
    logic   wait_trig;
    logic   snap_en;
    logic   defer;
    logic   count_up;
    tmode_e mode;
    logic   enable;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam logic [2:0] A_CFG    = 3'd0;
  localparam logic [2:0] A_LOAD   = 3'd1;
  localparam logic [2:0] A_PRE    = 3'd2;
  localparam logic [2:0] A_MATCH  = 3'd3;
  localparam logic [2:0] A_COUNT  = 3'd4;
  localparam logic [2:0] A_PSCNT  = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;
  localparam logic [2:0] A_MASKED = 3'd7;
endpackage

// File: rtl/ct_regs.sv
module ct_regs import chain_timer_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              to_evt,
  input  logic              match_evt,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  match_val,
  output logic [1:0]        status,
  output logic [1:0]        masked,
  output logic              load_wr,
  output logic              ps_wr,
  output logic              dma_trig,
  output logic              adc_trig
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] match_q;
  logic [1:0]       stat_q;
  logic [1:0]       clr;
  logic             cfg_wr;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
  assign cfg_wr  = wr_en && (wr_addr == ADDR_W'(A_CFG));
  assign load_wr = wr_en && (wr_addr == ADDR_W'(A_LOAD));
  assign ps_wr   = wr_en && (wr_addr == ADDR_W'(A_PRE));
  assign clr     = (wr_en && wr_addr == ADDR_W'(A_STATUS)) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      match_q <= '0;
      stat_q  <= '0;
    end else begin
      if (cfg_wr)
        cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
      else if (to_evt && cfg_q.mode == MODE_ONESHOT)
        cfg_q.enable <= 1'b0;
      if (wr_en && wr_addr == ADDR_W'(A_MATCH))
        match_q <= wr_data[CNT_W-1:0];
      // new events win over a clear in the same cycle
      stat_q <= (stat_q & ~clr) | {match_evt, to_evt};
    end
  end

  assign cfg       = cfg_q;
  assign match_val = match_q;
  assign status    = stat_q;
  assign masked    = stat_q & {cfg_q.match_ie, cfg_q.to_ie};
  assign dma_trig  = match_evt && cfg_q.match_ie && cfg_q.dma_en;
  assign adc_trig  = match_evt && cfg_q.match_ie && cfg_q.adc_en;

  assert_to_sets_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> stat_q[0]);
  assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (to_evt && cfg_q.mode == MODE_ONESHOT && !cfg_wr) |=> !cfg_q.enable);
  assert_trig_has_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_trig || adc_trig) |=> stat_q[1]);
endmodule

// File: rtl/ct_core.sv
module ct_core import chain_timer_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              load_wr,
  input  logic              ps_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  match_val,
  input  logic              chain_in,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  load_pend,
  output logic [CNT_W-1:0]  snap_cnt,
  output logic [PS_W-1:0]   ps_cnt,
  output logic [PS_W-1:0]   ps_pend,
  output logic [PS_W-1:0]   snap_ps,
  output logic              to_evt,
  output logic              match_evt,
  output logic              pwm_out
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [PS_W-1:0]  P_ONE = PS_W'(1);

  logic [CNT_W-1:0] cnt_q, load_act_q, load_nxt_q, snap_cnt_q;
  logic [PS_W-1:0]  ps_q, ps_act_q, ps_nxt_q, snap_ps_q;
  logic             en_q, started_q;
  logic             en_rise, running, tick, at_end, imm;
  logic [CNT_W-1:0] wd_cnt;
  logic [PS_W-1:0]  wd_ps;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
  assign wd_cnt  = wr_data[CNT_W-1:0];
  assign wd_ps   = wr_data[PS_W-1:0];
  assign en_rise = cfg.enable && !en_q;
  assign running = cfg.enable && started_q;
  assign tick    = (ps_q == '0);
  assign imm     = !cfg.defer || cfg.count_up;
  assign at_end  = cfg.count_up ? (cnt_q >= load_act_q) : (cnt_q == '0);
  assign to_evt  = running && tick && at_end;
  assign match_evt = running && tick && (cnt_q == match_val) &&
                     (cfg.mode == MODE_ONESHOT || cfg.mode == MODE_PERIODIC);
  assign pwm_out = running && (cfg.mode == MODE_PWM) && (cnt_q > match_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;      started_q  <= 1'b0;
      cnt_q <= '0;       load_act_q <= '0;  load_nxt_q <= '0;
      ps_q <= '0;        ps_act_q   <= '0;  ps_nxt_q   <= '0;
      snap_cnt_q <= '0;  snap_ps_q  <= '0;
    end else begin
      en_q <= cfg.enable;
      if (!cfg.enable)                          started_q <= 1'b0;
      else if (!cfg.wait_trig || chain_in)      started_q <= 1'b1;

      if (load_wr) load_nxt_q <= wd_cnt;
      if (ps_wr)   ps_nxt_q   <= wd_ps;

      // active load and prescale values
      if (en_rise) begin
        load_act_q <= load_nxt_q;
        ps_act_q   <= ps_nxt_q;
      end else begin
        if (load_wr && (imm || !cfg.enable))  load_act_q <= wd_cnt;
        else if (to_evt && !imm)              load_act_q <= load_nxt_q;
        if (ps_wr && (imm || !cfg.enable))    ps_act_q <= wd_ps;
        else if (to_evt && !imm)              ps_act_q <= ps_nxt_q;
      end

      // counter
      if (en_rise)
        cnt_q <= cfg.count_up ? '0 : load_nxt_q;
      else if (load_wr && cfg.enable && !cfg.count_up && !cfg.defer)
        cnt_q <= wd_cnt;
      else if (to_evt) begin
        if (cfg.mode != MODE_ONESHOT)
          cnt_q <= cfg.count_up ? '0 : (imm ? load_act_q : load_nxt_q);
      end else if (running && tick)
        cnt_q <= cfg.count_up ? cnt_q + C_ONE : cnt_q - C_ONE;

      // prescaler
      if (en_rise)
        ps_q <= ps_nxt_q;
      else if (ps_wr && cfg.enable && imm)
        ps_q <= wd_ps;
      else if (running)
        ps_q <= tick ? ((to_evt && !imm) ? ps_nxt_q : ps_act_q) : ps_q - P_ONE;

      if (to_evt && cfg.snap_en && cfg.mode == MODE_PERIODIC) begin
        snap_cnt_q <= cnt_q;
        snap_ps_q  <= ps_q;
      end
    end
  end

  assign cnt       = cnt_q;
  assign ps_cnt    = ps_q;
  assign load_pend = load_nxt_q;
  assign ps_pend   = ps_nxt_q;
  assign snap_cnt  = snap_cnt_q;
  assign snap_ps   = snap_ps_q;

  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.enable && en_q && !started_q && !load_wr && !ps_wr) |=> $stable(cnt_q));
  assert_ps_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ps_q <= ps_act_q));
endmodule

// File: rtl/chain_timer.sv
module chain_timer import chain_timer_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              chain_in,
  output logic              chain_out,
  output logic              pwm_out,
  output logic              irq,
  output logic              dma_match_trig,
  output logic              adc_match_trig
);
  cfg_t             cfg;
  logic [CNT_W-1:0] match_val, cnt, load_pend, snap_cnt;
  logic [PS_W-1:0]  ps_cnt, ps_pend, snap_ps;
  logic [1:0]       status, masked;
  logic             load_wr, ps_wr, to_evt, match_evt, snap_sel;

  ct_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .to_evt(to_evt), .match_evt(match_evt), .cfg(cfg), .match_val(match_val),
    .status(status), .masked(masked), .load_wr(load_wr), .ps_wr(ps_wr),
    .dma_trig(dma_match_trig), .adc_trig(adc_match_trig));

  ct_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)) core_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .load_wr(load_wr), .ps_wr(ps_wr),
    .wr_data(wr_data), .match_val(match_val), .chain_in(chain_in),
    .cnt(cnt), .load_pend(load_pend), .snap_cnt(snap_cnt), .ps_cnt(ps_cnt),
    .ps_pend(ps_pend), .snap_ps(snap_ps), .to_evt(to_evt), .match_evt(match_evt),
    .pwm_out(pwm_out));

  assign snap_sel  = cfg.snap_en && (cfg.mode == MODE_PERIODIC);
  assign chain_out = to_evt;
  assign irq       = |masked;

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(A_CFG):    rd_data = DATA_W'(cfg);
      ADDR_W'(A_LOAD):   rd_data = DATA_W'(load_pend);
      ADDR_W'(A_PRE):    rd_data = DATA_W'(ps_pend);
      ADDR_W'(A_MATCH):  rd_data = DATA_W'(match_val);
      ADDR_W'(A_COUNT):  rd_data = DATA_W'(snap_sel ? snap_cnt : cnt);
      ADDR_W'(A_PSCNT):  rd_data = DATA_W'(snap_sel ? snap_ps : ps_cnt);
      ADDR_W'(A_STATUS): rd_data = DATA_W'(status);
      default:           rd_data = DATA_W'(masked);
    endcase
  end
endmodule

// File: tb/chain_timer_tb_top.sv
`timescale 1ns/1ps
module chain_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, chain_in = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        chain_out, pwm_out, irq, dma_match_trig, adc_match_trig;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] EN = 1, PER = 2, PWM = 4, UP = 8, DEF = 16, SNAP = 32,
                          WAIT = 64, MIE = 128, TIE = 256, DMA = 512, ADC = 1024;
  // {up, load, prescale, expected period}
  localparam logic [31:0] VECS [6] = '{32'h00030004, 32'h00070110, 32'h01050006,
                                       32'h0102030C, 32'h00000203, 32'h01000001};

  always #2.5 clk = ~clk;

  chain_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .chain_in(chain_in),
    .chain_out(chain_out), .pwm_out(pwm_out), .irq(irq),
    .dma_match_trig(dma_match_trig), .adc_match_trig(adc_match_trig));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_to();
    int g = 0;
    do begin @(negedge clk); g++; end while (!chain_out && g < 5000);
  endtask

  task automatic measure(output int per);
    int n = 0;
    wait_to();
    do begin @(negedge clk); n++; end while (!chain_out && n < 5000);
    per = n;
  endtask

  task automatic run_count(input int cyc, output int n_to, output int n_dma, output int n_adc);
    n_to = 0; n_dma = 0; n_adc = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      n_to += int'(chain_out); n_dma += int'(dma_match_trig); n_adc += int'(adc_match_trig);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int per, a, b, c, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 cfg", v, 0);
    rd(3'd6, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 count", v, 0);
    chk("R1 outputs", {27'd0, irq, chain_out, pwm_out, dma_match_trig, adc_match_trig}, 0);

    // R2 period table
    foreach (VECS[k]) begin
      wr(3'd0, 0);
      wr(3'd1, {24'd0, VECS[k][23:16]});
      wr(3'd2, {24'd0, VECS[k][15:8]});
      wr(3'd0, EN | PER | (VECS[k][24] ? UP : 0));
      measure(per);
      chk("R2 period", per, {24'd0, VECS[k][7:0]});
    end

    // R3 immediate reload
    wr(3'd0, 0); wr(3'd2, 0); wr(3'd1, 100); wr(3'd0, EN | PER);
    repeat (4) @(negedge clk);
    wr(3'd1, 5); rd(3'd4, v); chk("R3 count after write", v, 5);
    measure(per); chk("R3 new period", per, 6);

    // R4 deferred reload
    wr(3'd0, 0); wr(3'd1, 20); wr(3'd0, EN | PER | DEF);
    wait_to(); wr(3'd1, 5); rd(3'd4, v); chk("R4 count undisturbed", v, 19);
    measure(per); chk("R4 period after timeout", per, 6);

    // R5 count up ignores defer
    wr(3'd0, 0); wr(3'd1, 50); wr(3'd0, EN | PER | UP | DEF);
    repeat (5) @(negedge clk);
    wr(3'd1, 10); measure(per); chk("R5 limit applied", per, 11);

    // R6 write while disabled
    wr(3'd0, 0); wr(3'd1, 7); wr(3'd0, EN | PER);
    @(negedge clk); rd(3'd4, v); chk("R6 loaded on enable", v, 7);
    measure(per); chk("R6 period", per, 8);

    // R8 snapshot
    wr(3'd0, 0); wr(3'd1, 9); wr(3'd2, 2); wr(3'd0, EN | PER | UP | SNAP);
    wait_to(); @(negedge clk);
    rd(3'd4, v); chk("R8 count snapshot", v, 9);
    rd(3'd5, v); chk("R8 prescale snapshot", v, 0);
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R8 snapshot held", v, 9);
    wr(3'd2, 0);

    // R9 wait on trigger
    wr(3'd0, 0); wr(3'd1, 6); wr(3'd0, EN | PER | WAIT);
    run_count(20, a, b, c); chk("R9 no timeout before trigger", a, 0);
    rd(3'd4, v); chk("R9 count held", v, 6);
    @(negedge clk); chain_in = 1'b1; hi = 0;
    do begin @(negedge clk); chain_in = 1'b0; hi++; end while (!chain_out && hi < 100);
    chk("R9 trigger to timeout", hi, 7);

    // R7 / R10 / R11 one-shot with match
    wr(3'd0, 0); wr(3'd6, 3); wr(3'd1, 4); wr(3'd3, 2);
    wr(3'd0, EN | MIE | TIE | DMA);
    run_count(30, a, b, c);
    chk("R7 single timeout", a, 1);
    chk("R11 dma pulse", b, 1);
    chk("R11 adc disabled", c, 0);
    rd(3'd0, v); chk("R7 enable cleared", v & 1, 0);
    rd(3'd6, v); chk("R10 status", v, 3);
    chk("R12 irq set", irq, 1);

    // R12 write one to clear
    wr(3'd6, 1); rd(3'd6, v); chk("R12 clear timeout", v, 2);
    wr(3'd6, 0); rd(3'd6, v); chk("R12 zero write", v, 2);
    chk("R12 irq from match", irq, 1);
    wr(3'd6, 2); rd(3'd6, v); chk("R12 all clear", v, 0);
    chk("R12 irq low", irq, 0);

    // R11 gating by match interrupt enable
    wr(3'd0, EN | DMA | ADC);
    run_count(30, a, b, c);
    chk("R11 dma gated", b, 0);
    chk("R11 adc gated", c, 0);
    rd(3'd6, v); chk("R10 raw status", v, 3);
    chk("R12 irq masked", irq, 0);

    // R13 PWM
    wr(3'd0, 0); wr(3'd1, 9); wr(3'd3, 3); wr(3'd6, 3); wr(3'd0, EN | PWM);
    wait_to(); hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); hi += int'(pwm_out); end
    chk("R13 pwm high cycles", hi, 6);
    rd(3'd6, v); chk("R10 no match in pwm", v & 2, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule